// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the control engine of a small byte-wide, sector-erasable non-volatile memory model. A host interface hands it already-decoded requests: program a byte, erase a set of sectors, erase the whole array, suspend, resume and software reset. The sequencer then drives an array held in registers. It times every program and erase pulse with cycle counters and holds a ready/busy output low while work is in progress. While an operation is running, a host read returns a status byte instead of array data.

Programming behaves like real floating-gate cells. A program pulse can only clear bits, so the stored byte becomes the old value AND the new data. The sequencer then verifies the byte and retries, up to a parameterised number of pulses. An erase has two phases. First, every byte of the targeted sectors is preprogrammed to 00h. Then each targeted sector is pulsed and set to FFh. An erase may be suspended during a pulse. While it is suspended, the host can read the sectors that are not being erased and program bytes in them, and a resume then finishes the erase. Two things block program and erase requests: a protection flag on the target sector, and a low supply-good input. A synchronous hardware reset input aborts any operation.

Top module: `flash_seq`

## Requirements
- R1: After power-on reset (rst_ni low), ready_o is 1 and every array byte reads FFh.
- R2: A program request (cmd_i=1) to an unprotected byte pulls ready_o low on the next cycle. The byte becomes old AND data. ready_o returns high PROG_CYC+1 cycles after acceptance when the verify matches.
- R3: A read during a program returns status: bit 7 is the complement of bit 7 of the data being written, and bit 6 changes on every such read.
- R4: If the verify still fails after MAX_PULSES pulses, status bit 5 is set and ready_o stays low. A reset command (cmd_i=6) returns the block to array reads, with the byte left at old AND data.
- R5: A sector erase (cmd_i=2, sect_mask_i bit n selects sector n = addr_i / SECT_BYTES) leaves every selected unprotected sector at FFh and the other sectors unchanged. Status bit 7 reads 0 during an erase.
- R6: An erase first preprograms all bytes of its sectors to 00h. A sector aborted during its erase pulse reads 00h.
- R7: A chip erase (cmd_i=3) erases every unprotected sector.
- R8: A program or erase aimed at a sector whose prot_i bit is 1 is not performed. A program to a protected sector leaves ready_o high and the byte unchanged.
- R9: An erase whose selected sectors are all protected holds ready_o low for exactly NOPROT_CYC cycles, then returns to array reads with the array unchanged.
- R10: With vdd_ok_i low, program and erase requests are ignored: ready_o stays high and the array is unchanged.
- R11: A suspend (cmd_i=4) during an erase pulse raises ready_o. Reads of sectors that are not being erased return array data. Reads of an erasing sector return status with bit 7 = 1, bit 6 held, and bit 2 changing on every read.
- R12: While suspended, a program to a non-erasing sector runs and then returns to the suspended state. A program to an erasing sector is ignored.
- R13: A resume (cmd_i=5) continues the interrupted pulse with its remaining count, and the erase completes.
- R14: hw_reset_i high aborts any operation: ready_o is 1 after the next edge, and the array keeps the value it had before the aborted pulse ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset; also sets the array to FFh |
| hw_reset_i | input | 1 | Synchronous abort to read mode; the array is kept |
| cmd_valid_i | input | 1 | Request strobe |
| cmd_i | input | 3 | 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume, 6 reset |
| addr_i | input | ADDR_W | Byte address for program and read |
| wdata_i | input | 8 | Program data |
| sect_mask_i | input | NUM_SECT | Sectors targeted by a sector erase |
| prot_i | input | NUM_SECT | Per-sector protection flags |
| vdd_ok_i | input | 1 | Supply-good; low blocks program and erase |
| rd_i | input | 1 | Read strobe; data appears on rdata_o after the next edge |
| rdata_o | output | 8 | Array data or status byte |
| ready_o | output | 1 | High when idle or suspended, low while busy |

## Verification
Programs are tried with data that only clears bits and with data that needs a 0-to-1 change. These two cases separate a passing verify from the retry-and-fail path. Erases use a mask that mixes protected and unprotected sectors, a fully protected mask, and a chip erase. This tells apart correct per-sector gating, the short empty-erase busy period and whole-array handling. Aborting in mid-erase exposes the preprogram phase, because the aborted sector reads 00h. The suspend run reads erasing and non-erasing sectors and programs both kinds, which shows where status is returned instead of data and which programs are refused.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [2:0] CMD_PGM  = 3'd1;
  localparam logic [2:0] CMD_SERS = 3'd2;
  localparam logic [2:0] CMD_CERS = 3'd3;
  localparam logic [2:0] CMD_SUSP = 3'd4;
  localparam logic [2:0] CMD_RES  = 3'd5;
  localparam logic [2:0] CMD_RST  = 3'd6;

  localparam int unsigned STB_POLL = 7;
  localparam int unsigned STB_TOG  = 6;
  localparam int unsigned STB_FAIL = 5;
  localparam int unsigned STB_TOG2 = 2;

  typedef enum logic [3:0] {
    ST_READ, ST_PGM, ST_VFY, ST_FAIL, ST_PRE, ST_ENXT, ST_EPUL, ST_SUSP, ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= len_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  // last counted cycle of the pulse
  assign done_o = run_i && (cnt_q == CNT_W'(1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int unsigned NUM_SECT   = 4,
  parameter int unsigned SECT_BYTES = 8,
  localparam int unsigned TOTAL  = NUM_SECT * SECT_BYTES,
  localparam int unsigned ADDR_W = $clog2(TOTAL),
  localparam int unsigned SECT_W = $clog2(NUM_SECT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic [ADDR_W-1:0] ver_addr_i,
  output logic [7:0]        ver_data_o,
  input  logic              prog_en_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [7:0]        prog_data_i,
  input  logic              erase_en_i,
  input  logic [SECT_W-1:0] erase_sect_i
);
  logic [TOTAL*8-1:0] flat_w;

  for (genvar b = 0; b < TOTAL; b++) begin : g_byte
    localparam logic [SECT_W-1:0] MY_SECT = SECT_W'(b / SECT_BYTES);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(b);
    logic [7:0] byte_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= 8'hFF;
      else if (erase_en_i && erase_sect_i == MY_SECT) byte_q <= 8'hFF;
      else if (prog_en_i && prog_addr_i == MY_ADDR) byte_q <= byte_q & prog_data_i;
    end

    assign flat_w[b*8 +: 8] = byte_q;
  end

  assign rd_data_o  = flat_w[{rd_addr_i, 3'b000} +: 8];
  assign ver_data_o = flat_w[{ver_addr_i, 3'b000} +: 8];
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flip_tog_i,
  input  logic       flip_tog2_i,
  input  logic       poll_i,
  input  logic       fail_i,
  output logic [7:0] stat_o
);
  logic tog_q, tog2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      tog2_q <= 1'b0;
    end else begin
      if (flip_tog_i)  tog_q  <= ~tog_q;
      if (flip_tog2_i) tog2_q <= ~tog2_q;
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[STB_POLL] = poll_i;
    stat_o[STB_TOG]  = tog_q;
    stat_o[STB_FAIL] = fail_i;
    stat_o[STB_TOG2] = tog2_q;
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned NUM_SECT   = 4,
  parameter int unsigned SECT_BYTES = 8,
  parameter int unsigned PROG_CYC   = 8,
  parameter int unsigned ERASE_CYC  = 32,
  parameter int unsigned MAX_PULSES = 3,
  parameter int unsigned NOPROT_CYC = 4,
  localparam int unsigned TOTAL  = NUM_SECT * SECT_BYTES,
  localparam int unsigned ADDR_W = $clog2(TOTAL)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_reset_i,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  input  logic [NUM_SECT-1:0] sect_mask_i,
  input  logic [NUM_SECT-1:0] prot_i,
  input  logic                vdd_ok_i,
  input  logic                rd_i,
  output logic [7:0]          rdata_o,
  output logic                ready_o
);
  localparam int unsigned SECT_W = $clog2(NUM_SECT);
  localparam int unsigned OFS_W  = $clog2(SECT_BYTES);
  localparam int unsigned PW     = $clog2(PROG_CYC + 1);
  localparam int unsigned EW     = $clog2(ERASE_CYC + NOPROT_CYC + 1);
  localparam int unsigned RW     = $clog2(MAX_PULSES + 1);

  seq_state_e          st_q;
  logic [ADDR_W-1:0]   op_addr_q, ptr_q;
  logic [7:0]          op_data_q, rdata_q;
  logic [RW-1:0]       retry_q;
  logic                fail_q, from_susp_q;
  logic [NUM_SECT-1:0] mask_q;

  logic [SECT_W-1:0]   cmd_sect, pre_sect, ptr_sect;
  logic                pgm_ok, ers_req, susp_cmd, res_cmd, rst_cmd;
  logic [NUM_SECT-1:0] req_mask, eff_mask;
  logic                p_start, p_run, p_done, e_start, e_run, e_done;
  logic [PW-1:0]       p_cnt;
  logic [EW-1:0]       e_cnt, e_len;
  logic                arr_prog_en, arr_erase_en;
  logic [ADDR_W-1:0]   arr_prog_addr;
  logic [7:0]          arr_prog_data, arr_rd, ver_rd, stat_w;
  logic                busy_w, susp_w, ers_busy_w, stat_sel, ptr_end, ver_ok, last_pulse;

  assign cmd_sect = addr_i[ADDR_W-1:OFS_W];
  assign pre_sect = ptr_q[ADDR_W-1:OFS_W];
  assign ptr_sect = ptr_q[SECT_W-1:0];
  assign ptr_end  = (ptr_q == ADDR_W'(NUM_SECT));

  assign susp_cmd = cmd_valid_i && cmd_i == CMD_SUSP;
  assign res_cmd  = cmd_valid_i && cmd_i == CMD_RES;
  assign rst_cmd  = cmd_valid_i && cmd_i == CMD_RST;

  assign busy_w     = !(st_q == ST_READ || st_q == ST_SUSP);
  assign susp_w     = (st_q == ST_SUSP);
  assign ers_busy_w = (st_q == ST_PRE) || (st_q == ST_ENXT) || (st_q == ST_EPUL) || (st_q == ST_HOLD);

  // a program is taken when idle, or when suspended and aimed away from the erasing sectors
  assign pgm_ok = cmd_valid_i && cmd_i == CMD_PGM && vdd_ok_i && !prot_i[cmd_sect] &&
                  (st_q == ST_READ || (st_q == ST_SUSP && !mask_q[cmd_sect]));
  assign req_mask = (cmd_i == CMD_CERS) ? '1 : sect_mask_i;
  assign eff_mask = req_mask & ~prot_i;
  assign ers_req  = cmd_valid_i && (cmd_i == CMD_SERS || cmd_i == CMD_CERS) && vdd_ok_i &&
                    st_q == ST_READ && req_mask != '0;

  assign ver_ok     = (ver_rd == op_data_q);
  assign last_pulse = (retry_q == RW'(MAX_PULSES - 1));

  // pulse timers: separate so a suspended erase keeps its count across a program
  assign p_start = pgm_ok || (st_q == ST_VFY && !ver_ok && !last_pulse);
  assign p_run   = (st_q == ST_PGM) && !hw_reset_i;
  assign e_start = (st_q == ST_ENXT && !ptr_end && mask_q[ptr_sect]) ||
                   (ers_req && eff_mask == '0);
  assign e_len   = (st_q == ST_READ) ? EW'(NOPROT_CYC) : EW'(ERASE_CYC);
  assign e_run   = ((st_q == ST_EPUL && !susp_cmd) || st_q == ST_HOLD) && !hw_reset_i;

  flash_pulse_timer #(.CNT_W(PW)) u_ptmr (
    .clk_i, .rst_ni, .start_i(p_start), .len_i(PW'(PROG_CYC)), .run_i(p_run),
    .done_o(p_done), .cnt_o(p_cnt)
  );

  flash_pulse_timer #(.CNT_W(EW)) u_etmr (
    .clk_i, .rst_ni, .start_i(e_start), .len_i(e_len), .run_i(e_run),
    .done_o(e_done), .cnt_o(e_cnt)
  );

  always_comb begin
    arr_prog_en   = 1'b0;
    arr_prog_addr = op_addr_q;
    arr_prog_data = op_data_q;
    if (st_q == ST_PRE) begin
      arr_prog_en   = mask_q[pre_sect] && !hw_reset_i;
      arr_prog_addr = ptr_q;
      arr_prog_data = 8'h00;
    end else if (st_q == ST_PGM) begin
      arr_prog_en = p_done;
    end
  end
  assign arr_erase_en = (st_q == ST_EPUL) && e_done;

  flash_cell_array #(.NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES)) u_arr (
    .clk_i, .rst_ni,
    .rd_addr_i(addr_i), .rd_data_o(arr_rd),
    .ver_addr_i(op_addr_q), .ver_data_o(ver_rd),
    .prog_en_i(arr_prog_en), .prog_addr_i(arr_prog_addr), .prog_data_i(arr_prog_data),
    .erase_en_i(arr_erase_en), .erase_sect_i(ptr_sect)
  );

  logic poll_w;
  always_comb begin
    case (st_q)
      ST_PGM, ST_VFY, ST_FAIL: poll_w = ~op_data_q[7];
      ST_SUSP:                 poll_w = 1'b1;
      default:                 poll_w = 1'b0;
    endcase
  end

  assign stat_sel = busy_w || (susp_w && mask_q[cmd_sect]);

  flash_status_gen u_stat (
    .clk_i, .rst_ni,
    .flip_tog_i(rd_i && busy_w),
    .flip_tog2_i(rd_i && mask_q[cmd_sect] && (ers_busy_w || susp_w)),
    .poll_i(poll_w), .fail_i(fail_q), .stat_o(stat_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_READ;
      op_addr_q   <= '0;
      op_data_q   <= '0;
      retry_q     <= '0;
      fail_q      <= 1'b0;
      from_susp_q <= 1'b0;
      mask_q      <= '0;
      ptr_q       <= '0;
      rdata_q     <= '0;
    end else begin
      if (rd_i) rdata_q <= stat_sel ? stat_w : arr_rd;
      if (hw_reset_i) begin
        st_q        <= ST_READ;
        fail_q      <= 1'b0;
        from_susp_q <= 1'b0;
        mask_q      <= '0;
        retry_q     <= '0;
      end else begin
        case (st_q)
          ST_READ: begin
            if (pgm_ok) begin
              op_addr_q   <= addr_i;
              op_data_q   <= wdata_i;
              retry_q     <= '0;
              from_susp_q <= 1'b0;
              st_q        <= ST_PGM;
            end else if (ers_req) begin
              mask_q <= eff_mask;
              ptr_q  <= '0;
              st_q   <= (eff_mask == '0) ? ST_HOLD : ST_PRE;
            end
          end
          ST_SUSP: begin
            if (pgm_ok) begin
              op_addr_q   <= addr_i;
              op_data_q   <= wdata_i;
              retry_q     <= '0;
              from_susp_q <= 1'b1;
              st_q        <= ST_PGM;
            end else if (res_cmd) begin
              st_q <= ST_EPUL;
            end
          end
          ST_PGM: if (p_done) st_q <= ST_VFY;
          ST_VFY: begin
            if (ver_ok) begin
              st_q <= from_susp_q ? ST_SUSP : ST_READ;
            end else if (last_pulse) begin
              fail_q <= 1'b1;
              st_q   <= ST_FAIL;
            end else begin
              retry_q <= retry_q + RW'(1);
              st_q    <= ST_PGM;
            end
          end
          ST_FAIL: begin
            if (rst_cmd) begin
              fail_q      <= 1'b0;
              from_susp_q <= 1'b0;
              mask_q      <= '0;
              st_q        <= ST_READ;
            end
          end
          ST_PRE: begin
            if (ptr_q == ADDR_W'(TOTAL - 1)) begin
              ptr_q <= '0;
              st_q  <= ST_ENXT;
            end else begin
              ptr_q <= ptr_q + ADDR_W'(1);
            end
          end
          ST_ENXT: begin
            if (ptr_end) begin
              mask_q <= '0;
              st_q   <= ST_READ;
            end else if (mask_q[ptr_sect]) begin
              st_q <= ST_EPUL;
            end else begin
              ptr_q <= ptr_q + ADDR_W'(1);
            end
          end
          ST_EPUL: begin
            if (susp_cmd) begin
              st_q <= ST_SUSP;
            end else if (e_done) begin
              ptr_q <= ptr_q + ADDR_W'(1);
              st_q  <= ST_ENXT;
            end
          end
          ST_HOLD: if (e_done) st_q <= ST_READ;
          default: st_q <= ST_READ;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
  assign ready_o = !busy_w;

  logic unused_w;
  assign unused_w = ^p_cnt;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int unsigned NUM_SECT = 4,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned OFS_W    = 3,
  parameter int unsigned EW       = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                hw_reset_i,
  input logic                cmd_valid_i,
  input logic [2:0]          cmd_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_SECT-1:0] prot_i,
  input logic                vdd_ok_i,
  input logic                rd_i,
  input logic                dq7_i,
  input logic                ready_o,
  input logic                susp_i,
  input logic                ers_busy_i,
  input logic                fail_i,
  input logic [NUM_SECT-1:0] mask_i,
  input logic [EW-1:0]       ecnt_i
);
  logic [ADDR_W-OFS_W-1:0] sect_w;
  assign sect_w = addr_i[ADDR_W-1:OFS_W];

  // R14
  a_r14_abort_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_reset_i |=> ready_o);

  // R8
  a_r8_prot_pgm_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cmd_valid_i && cmd_i == 3'd1 && prot_i[sect_w]) |=> ready_o);

  // R10
  a_r10_vdd_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cmd_valid_i && cmd_i inside {3'd1, 3'd2, 3'd3} && !vdd_ok_i) |=> ready_o);

  // R4
  a_r4_fail_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |-> !ready_o);

  // R5
  a_r5_erase_poll_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ers_busy_i) |=> !dq7_i);

  // R13
  a_r13_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_i && !(cmd_valid_i && cmd_i == 3'd5)) |=> $stable(ecnt_i));

  // R12
  a_r12_erasing_pgm_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_i && !hw_reset_i && cmd_valid_i && cmd_i == 3'd1 && mask_i[sect_w]) |=> (ready_o && susp_i));
endmodule

bind flash_seq flash_seq_chk #(
  .NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .EW(EW)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .hw_reset_i(hw_reset_i), .cmd_valid_i(cmd_valid_i),
  .cmd_i(cmd_i), .addr_i(addr_i), .prot_i(prot_i), .vdd_ok_i(vdd_ok_i), .rd_i(rd_i),
  .dq7_i(rdata_o[7]), .ready_o(ready_o), .susp_i(susp_w), .ers_busy_i(ers_busy_w),
  .fail_i(fail_q), .mask_i(mask_q), .ecnt_i(e_cnt)
);

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
  localparam int unsigned NS = 4;
  localparam int unsigned SB = 8;
  localparam int unsigned AW = 5;
  localparam int unsigned NOPROT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_rst = 1'b0;
  logic          cv = 1'b0;
  logic [2:0]    cmd = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wd = '0;
  logic [NS-1:0] smask = '0;
  logic [NS-1:0] prot = '0;
  logic          vdd = 1'b1;
  logic          rd = 1'b0;
  logic [7:0]    rdata;
  logic          ready;

  int n_chk = 0;
  int n_err = 0;
  bit raw = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  flash_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_reset_i(hw_rst), .cmd_valid_i(cv), .cmd_i(cmd),
    .addr_i(addr), .wdata_i(wd), .sect_mask_i(smask), .prot_i(prot), .vdd_ok_i(vdd),
    .rd_i(rd), .rdata_o(rdata), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] c, input int a, input logic [7:0] d, input logic [NS-1:0] m);
    cv = 1'b1; cmd = c; addr = AW'(a); wd = d; smask = m;
    @(negedge clk);
    cv = 1'b0;
  endtask

  // driver: push expected byte, monitor compares
  task automatic rd_exp(input int a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_raw(input int a, output logic [7:0] v);
    raw = 1'b1; rd = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd = 1'b0; raw = 1'b0;
    v = rdata;
  endtask

  task automatic wait_ready(input string tag);
    for (int i = 0; i < 3000; i++) begin
      if (ready) break;
      cyc(1);
    end
    chk(ready == 1'b1, tag, ready, 1);
  endtask

  task automatic hw_pulse();
    hw_rst = 1'b1;
    @(negedge clk);
    hw_rst = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rd && !raw) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk(1'b0, "monitor underflow", 0, 1);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rdata == e, t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s0, s1;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    for (int a = 0; a < NS * SB; a++) rd_exp(a, 8'hFF, "R1 erased array");

    // program, exact timing and status
    send(3'd1, 5, 8'hA5, '0);
    chk(ready == 1'b0, "R2 busy after program", ready, 0);
    rd_raw(5, s0);
    rd_raw(5, s1);
    chk(s0[7] == 1'b0, "R3 poll bit complement of 1", s0[7], 0);
    chk(s0[6] != s1[6], "R3 toggle changes", s1[6], ~s0[6]);
    cyc(6);
    chk(ready == 1'b0, "R2 still verifying", ready, 0);
    cyc(1);
    chk(ready == 1'b1, "R2 ready after pulse+verify", ready, 1);
    rd_exp(5, 8'hA5, "R2 programmed byte");

    send(3'd1, 9, 8'h3C, '0);
    rd_raw(9, s0);
    chk(s0[7] == 1'b1, "R3 poll bit complement of 0", s0[7], 1);
    wait_ready("R2 second program done");
    rd_exp(9, 8'h3C, "R2 second byte");

    // verify failure
    send(3'd1, 5, 8'hFF, '0);
    cyc(40);
    chk(ready == 1'b0, "R4 stuck busy", ready, 0);
    rd_raw(5, s0);
    chk(s0[5] == 1'b1, "R4 limit bit", s0[5], 1);
    send(3'd6, 0, 8'h00, '0);
    chk(ready == 1'b1, "R4 reset command recovers", ready, 1);
    rd_exp(5, 8'hA5, "R4 byte old AND data");
    send(3'd1, 5, 8'h05, '0);
    wait_ready("R2 clearing program");
    rd_exp(5, 8'h05, "R2 AND semantics");

    // protection and supply
    prot = 4'b0100;
    send(3'd1, 17, 8'h12, '0);
    chk(ready == 1'b1, "R8 protected program ignored", ready, 1);
    rd_exp(17, 8'hFF, "R8 protected byte unchanged");
    vdd = 1'b0;
    send(3'd1, 0, 8'h00, '0);
    chk(ready == 1'b1, "R10 program blocked", ready, 1);
    send(3'd2, 0, 8'h00, 4'b0001);
    chk(ready == 1'b1, "R10 erase blocked", ready, 1);
    rd_exp(0, 8'hFF, "R10 byte unchanged");
    vdd = 1'b1;

    // sector erase with a protected sector in the mask
    send(3'd1, 12, 8'h11, '0);
    wait_ready("R2 program sector1");
    send(3'd2, 0, 8'h00, 4'b0110);
    rd_raw(0, s0);
    chk(s0[7] == 1'b0, "R5 poll bit during erase", s0[7], 0);
    wait_ready("R5 erase done");
    rd_exp(9, 8'hFF, "R5 sector1 erased");
    rd_exp(12, 8'hFF, "R5 sector1 erased");
    rd_exp(5, 8'h05, "R5 sector0 untouched");

    // all selected sectors protected
    send(3'd2, 0, 8'h00, 4'b0100);
    chk(ready == 1'b0, "R9 brief busy", ready, 0);
    cyc(NOPROT - 1);
    chk(ready == 1'b0, "R9 busy until end", ready, 0);
    cyc(1);
    chk(ready == 1'b1, "R9 ready after hold", ready, 1);
    rd_exp(5, 8'h05, "R9 array unchanged");

    // abort mid-erase shows preprogram
    send(3'd1, 24, 8'h77, '0);
    wait_ready("R2 program sector3");
    send(3'd2, 0, 8'h00, 4'b1000);
    cyc(50);
    hw_pulse();
    chk(ready == 1'b1, "R14 abort erase", ready, 1);
    rd_exp(24, 8'h00, "R6 preprogrammed");
    rd_exp(31, 8'h00, "R6 preprogrammed");
    rd_exp(5, 8'h05, "R14 other sector kept");

    // chip erase
    prot = 4'b0000;
    send(3'd1, 20, 8'h5A, '0);
    wait_ready("R2 program sector2");
    prot = 4'b0100;
    send(3'd3, 0, 8'h00, '0);
    wait_ready("R7 chip erase done");
    rd_exp(5, 8'hFF, "R7 sector0");
    rd_exp(24, 8'hFF, "R7 sector3");
    rd_exp(20, 8'h5A, "R8 protected in chip erase");

    // abort a program
    send(3'd1, 26, 8'h00, '0);
    cyc(3);
    hw_pulse();
    chk(ready == 1'b1, "R14 abort program", ready, 1);
    rd_exp(26, 8'hFF, "R14 byte unchanged");

    // suspend / resume
    prot = 4'b0000;
    send(3'd1, 2, 8'h0F, '0);
    wait_ready("R2 program sector0");
    send(3'd1, 10, 8'hF0, '0);
    wait_ready("R2 program sector1");
    send(3'd2, 0, 8'h00, 4'b0001);
    cyc(50);
    send(3'd4, 0, 8'h00, '0);
    chk(ready == 1'b1, "R11 suspended ready", ready, 1);
    rd_exp(10, 8'hF0, "R11 non-erasing read");
    rd_raw(2, s0);
    rd_raw(2, s1);
    chk(s0[7] == 1'b1, "R11 suspend poll bit", s0[7], 1);
    chk(s0[6] == s1[6], "R11 toggle held", s1[6], s0[6]);
    chk(s0[2] != s1[2], "R11 erasing toggle", s1[2], ~s0[2]);
    send(3'd1, 11, 8'h44, '0);
    chk(ready == 1'b0, "R12 program in suspend runs", ready, 0);
    wait_ready("R12 program in suspend done");
    rd_exp(11, 8'h44, "R12 programmed in suspend");
    rd_raw(2, s0);
    chk(s0[7] == 1'b1, "R12 back in suspend", s0[7], 1);
    send(3'd1, 3, 8'h00, '0);
    chk(ready == 1'b1, "R12 erasing-sector program refused", ready, 1);
    send(3'd5, 0, 8'h00, '0);
    chk(ready == 1'b0, "R13 resumed busy", ready, 0);
    wait_ready("R13 erase finished");
    rd_exp(2, 8'hFF, "R13 sector0 erased");
    rd_exp(3, 8'hFF, "R13 sector0 erased");
    rd_exp(10, 8'hF0, "R13 sector1 kept");
    rd_exp(11, 8'h44, "R13 suspend program kept");

    cyc(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule